// File: doc/BRIEF.md
# Endpoint Configuration Header and Memory Window Decoder

This block holds the configuration header of a simple memory-space endpoint and decodes the memory windows that the header describes. A configuration port reads and writes 32-bit registers by dword index. Behind this port are a fixed identity word, a command register that carries only a decode-enable bit, and six base-address slots. Each slot is set at build time to one of four kinds: unused, a 32-bit window, the low half of a 64-bit window, or the high half that pairs with the slot below it. A slot answers the standard sizing handshake: software writes all ones, reads back a mask in which the address bits below the window size are zero, and then writes back a real base.

A second port carries memory requests with a 64-bit address. The block compares each request against every programmed window. On a hit it passes the request on to a local memory, one cycle later, as a read strobe or as a write with data. The local address is the offset of the request inside the window. A request that hits no window, or that arrives while decode is off, is flagged as unsupported and is not passed on.

Top module: `ep_cfg_window`

## Requirements
- R1: Dword index 0 reads {DEVICE_ID, VENDOR_ID}, with the vendor identifier in bits 15:0. Writes to index 0 have no effect.
- R2: The six slots sit at dword indices 4 to 9 (byte offsets 0x10 to 0x24). For a window slot, bit 0 reads 0, bits 2:1 read 00 for a 32-bit window and 10 for a 64-bit low half, and bit 3 reads the prefetchable flag. These four bits ignore writes. A 64-bit high half has no attribute bits.
- R3: A window slot of size 2^L stores only bits 31:L. Writing all ones reads back those bits set, with the bits below them zero apart from the attributes. A base written after the probe reads back masked the same way.
- R4: In a 64-bit pair the high slot stores all 32 bits. The window base is {high slot, low slot with its low L bits cleared}, and a request decodes only when its upper 32 address bits equal the high slot.
- R5: An unused slot reads zero and ignores writes.
- R6: Dword index 1 reads {30'b0, en, 1'b0}. Only bit 1 (en, the decode enable) is writable, and it resets to 0.
- R7: Every other dword index reads zero, and writes to it leave all readable state unchanged.
- R8: A request that hits a window gives, in the cycle after mem_req, loc_wr (write) or loc_rd (read), loc_bar equal to the slot index, loc_off equal to the request address minus the window base, and loc_wdata equal to the request data for a write. When nothing is forwarded, loc_bar, loc_off and loc_wdata are zero.
- R9: A request that hits no window, or arrives while en is 0, raises mem_ur for one cycle in the cycle after mem_req and forwards nothing. At most one of loc_wr, loc_rd and mem_ur is high in any cycle.
- R10: When windows overlap, the lowest-numbered hitting slot takes the request.
- R11: A configuration read raises cfg_rvalid with the register value in the next cycle. While cfg_rvalid is low, cfg_rdata is zero. After reset all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_req | input | 1 | Configuration access this cycle |
| cfg_we | input | 1 | 1 = write, 0 = read |
| cfg_idx | input | 6 | Dword index of the register |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rvalid | output | 1 | Read data valid |
| cfg_rdata | output | 32 | Read data |
| mem_req | input | 1 | Memory request this cycle |
| mem_we | input | 1 | 1 = write, 0 = read |
| mem_addr | input | 64 | Request address |
| mem_wdata | input | 32 | Request write data |
| loc_wr | output | 1 | Forwarded write strobe |
| loc_rd | output | 1 | Forwarded read strobe |
| loc_bar | output | 3 | Index of the slot that took the request |
| loc_off | output | LOCAL_AW | Offset within the window |
| loc_wdata | output | 32 | Forwarded write data |
| mem_ur | output | 1 | Request unsupported (miss or decode off) |

## Verification
The bench builds the block with slot 0 as a 32-bit 64 KB window, slots 2 and 3 as a prefetchable 64-bit 4 KB pair, slot 4 as a 32-bit 256-byte window, and slots 1 and 5 unused. This gives sizing probes at three sizes, a 64-bit window whose high half can miss while the low bits match, and two unused slots. Slot 4 can be placed inside slot 0, which exercises the priority between windows. LOCAL_AW stays at 16 so that the largest window fills the offset exactly.

// File: rtl/ep_cfg_pkg.sv
package ep_cfg_pkg;

  typedef enum logic [1:0] {
    SLOT_NONE   = 2'd0,
    SLOT_M32    = 2'd1,
    SLOT_M64_LO = 2'd2,
    SLOT_M64_HI = 2'd3
  } slot_kind_e;

  localparam int unsigned NUM_SLOTS  = 6;
  localparam int unsigned IDX_W      = 6;
  localparam logic [5:0]  IDX_IDENT  = 6'd0;
  localparam logic [5:0]  IDX_CMD    = 6'd1;
  localparam logic [5:0]  IDX_SLOT0  = 6'd4;
  localparam int unsigned CMD_EN_BIT = 1;

  // Bits a slot stores; everything else reads as constant.
  function automatic logic [31:0] slot_wmask(slot_kind_e k, int unsigned lg);
    logic [31:0] m;
    case (k)
      SLOT_M32, SLOT_M64_LO: m = ~((32'd1 << lg) - 32'd1);
      SLOT_M64_HI:           m = 32'hFFFF_FFFF;
      default:               m = 32'h0;
    endcase
    return m;
  endfunction

  // Read-only attribute nibble of a slot.
  function automatic logic [3:0] slot_attr(slot_kind_e k, logic pref);
    logic [3:0] a;
    case (k)
      SLOT_M32:    a = {pref, 2'b00, 1'b0};
      SLOT_M64_LO: a = {pref, 2'b10, 1'b0};
      default:     a = 4'h0;
    endcase
    return a;
  endfunction

endpackage

// File: rtl/ep_bar_slot.sv
module ep_bar_slot
  import ep_cfg_pkg::*;
#(
  parameter slot_kind_e  KIND = SLOT_NONE,
  parameter int unsigned LOG2 = 4,
  parameter logic        PREF = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wdata,
  output logic [31:0] base_q,
  output logic [31:0] rd_val
);

  localparam logic [31:0] WMASK = slot_wmask(KIND, LOG2);
  localparam logic [3:0]  ATTR  = slot_attr(KIND, PREF);

  logic [31:0] base_d;
  logic [31:0] base_r;

  always_comb begin
    base_d = wdata & WMASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_r <= '0;
    end else if (wr_en) begin
      base_r <= base_d;
    end
  end

  assign base_q = base_r;
  assign rd_val = base_r | {28'h0, ATTR};

  // R3: an all-ones probe reads back exactly the size mask plus attributes
  assert_probe_mask_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wdata == 32'hFFFF_FFFF)) |=> (rd_val == (WMASK | {28'h0, ATTR})));

endmodule

// File: rtl/ep_win_decode.sv
module ep_win_decode
  import ep_cfg_pkg::*;
#(
  parameter logic [2*NUM_SLOTS-1:0] BAR_KIND = '0,
  parameter logic [6*NUM_SLOTS-1:0] BAR_LOG2 = '0,
  parameter int unsigned            LOCAL_AW = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                dec_en,
  input  logic [63:0]         addr,
  input  logic [31:0]         bar_base [NUM_SLOTS],
  output logic                hit,
  output logic [2:0]          sel,
  output logic [LOCAL_AW-1:0] off
);

  logic [NUM_SLOTS-1:0] win_hit;
  logic [LOCAL_AW-1:0]  win_off [NUM_SLOTS];

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_win
    localparam slot_kind_e  K     = slot_kind_e'(BAR_KIND[2*i +: 2]);
    localparam int unsigned LG    = BAR_LOG2[6*i +: 6];
    localparam logic [63:0] AMASK = ~((64'd1 << LG) - 64'd1);
    logic [63:0] base;
    if (K == SLOT_M64_LO && i < NUM_SLOTS - 1) begin : g_pair
      assign base       = {bar_base[i+1], bar_base[i]};
      assign win_hit[i] = dec_en && (((addr ^ base) & AMASK) == 64'h0);
    end else if (K == SLOT_M32) begin : g_single
      assign base       = {32'h0, bar_base[i]};
      assign win_hit[i] = dec_en && (((addr ^ base) & AMASK) == 64'h0);
    end else begin : g_off
      assign base       = 64'h0;
      assign win_hit[i] = 1'b0;
    end
    // base is aligned to the window size, so the offset is just the low bits
    assign win_off[i] = addr[LOCAL_AW-1:0] & ~AMASK[LOCAL_AW-1:0];
  end

  always_comb begin
    hit = 1'b0;
    sel = 3'd0;
    off = '0;
    for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
      if (win_hit[i]) begin
        hit = 1'b1;
        sel = 3'(i);
        off = win_off[i];
      end
    end
  end

  // R10: no lower-numbered slot hits when a slot is selected
  assert_lowest_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> ((win_hit & ((6'd1 << sel) - 6'd1)) == 6'd0));

endmodule

// File: rtl/ep_cfg_window.sv
module ep_cfg_window
  import ep_cfg_pkg::*;
#(
  parameter logic [15:0]            VENDOR_ID = 16'h1D0F,
  parameter logic [15:0]            DEVICE_ID = 16'hA5C3,
  parameter logic [2*NUM_SLOTS-1:0] BAR_KIND  = 12'h1E1,
  parameter logic [6*NUM_SLOTS-1:0] BAR_LOG2  = {6'd0, 6'd8, 6'd0, 6'd12, 6'd0, 6'd16},
  parameter logic [NUM_SLOTS-1:0]   BAR_PREF  = 6'b000100,
  parameter int unsigned            LOCAL_AW  = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_req,
  input  logic                cfg_we,
  input  logic [5:0]          cfg_idx,
  input  logic [31:0]         cfg_wdata,
  output logic                cfg_rvalid,
  output logic [31:0]         cfg_rdata,
  input  logic                mem_req,
  input  logic                mem_we,
  input  logic [63:0]         mem_addr,
  input  logic [31:0]         mem_wdata,
  output logic                loc_wr,
  output logic                loc_rd,
  output logic [2:0]          loc_bar,
  output logic [LOCAL_AW-1:0] loc_off,
  output logic [31:0]         loc_wdata,
  output logic                mem_ur
);

  // configuration side
  logic        cfg_wr;
  logic        cfg_rd;
  logic        cmd_wr;
  logic        en_q;
  logic [31:0] slot_base [NUM_SLOTS];
  logic [31:0] slot_rd   [NUM_SLOTS];
  logic [31:0] rd_mux;
  logic [31:0] rdata_d;
  logic        seen_q;

  assign cfg_wr = cfg_req && cfg_we;
  assign cfg_rd = cfg_req && !cfg_we;
  assign cmd_wr = cfg_wr && (cfg_idx == IDX_CMD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0;
    end else if (cmd_wr) begin
      en_q <= cfg_wdata[CMD_EN_BIT];
    end
  end

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    localparam logic [5:0] MY_IDX = 6'(IDX_SLOT0 + 6'(i));
    logic slot_we;
    assign slot_we = cfg_wr && (cfg_idx == MY_IDX);
    ep_bar_slot #(
      .KIND (slot_kind_e'(BAR_KIND[2*i +: 2])),
      .LOG2 (BAR_LOG2[6*i +: 6]),
      .PREF (BAR_PREF[i])
    ) i_slot (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (slot_we),
      .wdata  (cfg_wdata),
      .base_q (slot_base[i]),
      .rd_val (slot_rd[i])
    );
  end

  always_comb begin
    rd_mux = 32'h0;
    if (cfg_idx == IDX_IDENT) begin
      rd_mux = {DEVICE_ID, VENDOR_ID};
    end else if (cfg_idx == IDX_CMD) begin
      rd_mux = {30'h0, en_q, 1'b0};
    end else begin
      for (int i = 0; i < NUM_SLOTS; i++) begin
        if (cfg_idx == 6'(IDX_SLOT0 + 6'(i))) begin
          rd_mux = slot_rd[i];
        end
      end
    end
    rdata_d = cfg_rd ? rd_mux : 32'h0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_rvalid <= 1'b0;
      cfg_rdata  <= '0;
      seen_q     <= 1'b0;
    end else begin
      cfg_rvalid <= cfg_rd;
      cfg_rdata  <= rdata_d;
      seen_q     <= 1'b1;
    end
  end

  // memory side
  logic                dec_hit;
  logic [2:0]          dec_sel;
  logic [LOCAL_AW-1:0] dec_off;
  logic                fwd;
  logic                wr_d;
  logic                rd_d;
  logic                ur_d;
  logic [2:0]          bar_d;
  logic [LOCAL_AW-1:0] off_d;
  logic [31:0]         wdat_d;

  ep_win_decode #(
    .BAR_KIND (BAR_KIND),
    .BAR_LOG2 (BAR_LOG2),
    .LOCAL_AW (LOCAL_AW)
  ) i_dec (
    .clk      (clk),
    .rst_n    (rst_n),
    .dec_en   (en_q),
    .addr     (mem_addr),
    .bar_base (slot_base),
    .hit      (dec_hit),
    .sel      (dec_sel),
    .off      (dec_off)
  );

  always_comb begin
    fwd    = mem_req && dec_hit;
    wr_d   = fwd && mem_we;
    rd_d   = fwd && !mem_we;
    ur_d   = mem_req && !dec_hit;
    bar_d  = fwd ? dec_sel : 3'd0;
    off_d  = fwd ? dec_off : '0;
    wdat_d = wr_d ? mem_wdata : 32'h0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loc_wr    <= 1'b0;
      loc_rd    <= 1'b0;
      mem_ur    <= 1'b0;
      loc_bar   <= '0;
      loc_off   <= '0;
      loc_wdata <= '0;
    end else begin
      loc_wr    <= wr_d;
      loc_rd    <= rd_d;
      mem_ur    <= ur_d;
      loc_bar   <= bar_d;
      loc_off   <= off_d;
      loc_wdata <= wdat_d;
    end
  end

  // R9: a single outcome per cycle
  assert_one_outcome_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({loc_wr, loc_rd, mem_ur}));

  // R9: decode disabled means the request is refused
  assert_off_refused_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && $past(mem_req && !en_q)) |-> (mem_ur && !loc_wr && !loc_rd));

  // R11: read data returns one cycle after the read
  assert_read_latency_R11: assert property (@(posedge clk) disable iff (!rst_n)
    seen_q |-> (cfg_rvalid == $past(cfg_req && !cfg_we)));

  // R11: data is quiet when not valid
  assert_quiet_rdata_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_rvalid |-> (cfg_rdata == 32'h0));

  // R8: the selected window reports an offset only when something is forwarded
  assert_idle_fields_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(loc_wr || loc_rd) |-> (loc_bar == 3'd0 && loc_off == '0 && loc_wdata == 32'h0));

endmodule

// File: tb/test_ep_cfg_window.sv
module test_ep_cfg_window;

  localparam int          CLK_PERIOD = 10;
  localparam int          LAW        = 16;
  localparam logic [15:0] VEN        = 16'h1D0F;
  localparam logic [15:0] DEV        = 16'hA5C3;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            cfg_req, cfg_we;
  logic [5:0]      cfg_idx;
  logic [31:0]     cfg_wdata;
  logic            cfg_rvalid;
  logic [31:0]     cfg_rdata;
  logic            mem_req, mem_we;
  logic [63:0]     mem_addr;
  logic [31:0]     mem_wdata;
  logic            loc_wr, loc_rd, mem_ur;
  logic [2:0]      loc_bar;
  logic [LAW-1:0]  loc_off;
  logic [31:0]     loc_wdata;

  int n_tests = 0;
  int n_fail  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ep_cfg_window #(
    .VENDOR_ID (VEN),
    .DEVICE_ID (DEV),
    .BAR_KIND  (12'h1E1),
    .BAR_LOG2  ({6'd0, 6'd8, 6'd0, 6'd12, 6'd0, 6'd16}),
    .BAR_PREF  (6'b000100),
    .LOCAL_AW  (LAW)
  ) i_ep_cfg_window (
    .clk, .rst_n, .cfg_req, .cfg_we, .cfg_idx, .cfg_wdata, .cfg_rvalid, .cfg_rdata,
    .mem_req, .mem_we, .mem_addr, .mem_wdata,
    .loc_wr, .loc_rd, .loc_bar, .loc_off, .loc_wdata, .mem_ur
  );

  // ---- behavioural reference ----
  logic [31:0] m_bar [6];
  logic        m_en;

  // window size log2 per slot (0 = no window of its own)
  function automatic int sz_log2(int s);
    case (s)
      0: return 16;
      2: return 12;
      4: return 8;
      default: return 0;
    endcase
  endfunction

  function automatic logic [31:0] keep_mask(int s);
    if (s == 3) return 32'hFFFF_FFFF;
    if (sz_log2(s) == 0) return 32'h0;
    return 32'hFFFF_FFFF << sz_log2(s);
  endfunction

  function automatic logic [31:0] attr(int s);
    if (s == 2) return 32'h0000_000C;   // 64-bit, prefetchable
    return 32'h0;
  endfunction

  function automatic logic [31:0] m_read(logic [5:0] idx);
    int d = int'(idx);
    if (d == 0) return {DEV, VEN};
    if (d == 1) return {30'h0, m_en, 1'b0};
    if (d >= 4 && d <= 9) return m_bar[d-4] | attr(d-4);
    return 32'h0;
  endfunction

  task automatic m_write(logic [5:0] idx, logic [31:0] v);
    int d = int'(idx);
    if (d == 1) m_en = v[1];
    else if (d >= 4 && d <= 9) m_bar[d-4] = v & keep_mask(d-4);
  endtask

  // ---- one clock of stimulus and comparison ----
  task automatic cyc(input string tag,
                     input logic c_req, input logic c_we, input logic [5:0] c_idx,
                     input logic [31:0] c_wd,
                     input logic m_req, input logic m_we, input logic [63:0] m_addr,
                     input logic [31:0] m_wd);
    logic        e_rv, e_wr, e_rd, e_ur;
    logic [31:0] e_rd_data, e_wdat;
    logic [2:0]  e_bar;
    logic [LAW-1:0] e_off;
    logic [63:0] base, size;
    logic        found;
    cfg_req = c_req; cfg_we = c_we; cfg_idx = c_idx; cfg_wdata = c_wd;
    mem_req = m_req; mem_we = m_we; mem_addr = m_addr; mem_wdata = m_wd;
    e_rv = c_req && !c_we;
    e_rd_data = e_rv ? m_read(c_idx) : 32'h0;
    found = 1'b0; e_bar = 3'd0; e_off = '0;
    for (int s = 0; s < 6; s++) begin
      if (!found && m_en && sz_log2(s) != 0) begin
        base = (s == 2) ? {m_bar[3], m_bar[2]} : {32'h0, m_bar[s]};
        size = 64'd1 << sz_log2(s);
        if (m_addr >= base && m_addr - base < size) begin
          found = 1'b1; e_bar = 3'(s); e_off = LAW'(m_addr - base);
        end
      end
    end
    e_wr = m_req && found && m_we;
    e_rd = m_req && found && !m_we;
    e_ur = m_req && !found;
    e_wdat = e_wr ? m_wd : 32'h0;
    if (!(e_wr || e_rd)) begin e_bar = 3'd0; e_off = '0; end
    if (c_req && c_we) m_write(c_idx, c_wd);
    @(negedge clk);
    n_tests++;
    if (cfg_rvalid !== e_rv || cfg_rdata !== e_rd_data || loc_wr !== e_wr ||
        loc_rd !== e_rd || mem_ur !== e_ur || loc_bar !== e_bar ||
        loc_off !== e_off || loc_wdata !== e_wdat) begin
      n_fail++;
      $display("FAIL %s: got rv=%0b rd=%h wr=%0b rd=%0b ur=%0b bar=%0d off=%h wd=%h; exp rv=%0b rd=%h wr=%0b rd=%0b ur=%0b bar=%0d off=%h wd=%h",
               tag, cfg_rvalid, cfg_rdata, loc_wr, loc_rd, mem_ur, loc_bar, loc_off, loc_wdata,
               e_rv, e_rd_data, e_wr, e_rd, e_ur, e_bar, e_off, e_wdat);
    end
  endtask

  task automatic cfg_w(input string tag, input logic [5:0] idx, input logic [31:0] v);
    cyc(tag, 1'b1, 1'b1, idx, v, 1'b0, 1'b0, 64'h0, 32'h0);
  endtask

  task automatic cfg_r(input string tag, input logic [5:0] idx);
    cyc(tag, 1'b1, 1'b0, idx, 32'h0, 1'b0, 1'b0, 64'h0, 32'h0);
  endtask

  task automatic mem(input string tag, input logic we, input logic [63:0] a, input logic [31:0] d);
    cyc(tag, 1'b0, 1'b0, 6'd0, 32'h0, 1'b1, we, a, d);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog: got running, exp finished");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    for (int s = 0; s < 6; s++) m_bar[s] = 32'h0;
    m_en = 1'b0;
    rst_n = 1'b0;
    cfg_req = 0; cfg_we = 0; cfg_idx = '0; cfg_wdata = '0;
    mem_req = 0; mem_we = 0; mem_addr = '0; mem_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // reset state, R11
    cyc("R11", 0, 0, 6'd0, 32'h0, 0, 0, 64'h0, 32'h0);

    // R1 identity word, writes ignored
    cfg_r("R1", 6'd0);
    cfg_w("R1", 6'd0, 32'h1234_5678);
    cfg_r("R1", 6'd0);

    // R2 slot attributes at reset
    for (int s = 0; s < 6; s++) cfg_r("R2", 6'(4 + s));
    cfg_w("R2", 6'd6, 32'h0000_0003);
    cfg_r("R2", 6'd6);

    // R3 sizing probe and restore on the 64 KB slot
    cfg_w("R3", 6'd4, 32'hFFFF_FFFF);
    cfg_r("R3", 6'd4);
    cfg_w("R3", 6'd4, 32'h5550_0000);
    cfg_r("R3", 6'd4);
    cfg_w("R3", 6'd8, 32'hFFFF_FFFF);
    cfg_r("R3", 6'd8);

    // R4 64-bit pair
    cfg_w("R4", 6'd6, 32'hFFFF_FFFF);
    cfg_r("R4", 6'd6);
    cfg_w("R4", 6'd7, 32'hFFFF_FFFF);
    cfg_r("R4", 6'd7);
    cfg_w("R4", 6'd6, 32'h1234_5678);
    cfg_w("R4", 6'd7, 32'h0000_0002);
    cfg_r("R4", 6'd6);
    cfg_r("R4", 6'd7);

    // R5 unused slots
    cfg_w("R5", 6'd5, 32'hFFFF_FFFF);
    cfg_r("R5", 6'd5);
    cfg_w("R5", 6'd9, 32'hA5A5_A5A5);
    cfg_r("R5", 6'd9);

    // R7 unimplemented indices
    cfg_w("R7", 6'd2, 32'hFFFF_FFFF);
    cfg_r("R7", 6'd2);
    cfg_w("R7", 6'd63, 32'hFFFF_FFFF);
    cfg_r("R7", 6'd63);
    cfg_r("R7", 6'd1);

    // R9 decode off
    mem("R9", 1'b1, 64'h5550_1230, 32'hDEAD_BEEF);

    // R6 command enable
    cfg_w("R6", 6'd1, 32'hFFFF_FFFF);
    cfg_r("R6", 6'd1);

    // R8 forwarding
    mem("R8", 1'b1, 64'h5550_1230, 32'hDEAD_BEEF);
    mem("R8", 1'b0, 64'h5550_FFFC, 32'h1111_1111);
    mem("R8", 1'b1, 64'h5550_0000, 32'h0BAD_F00D);
    cyc("R8", 0, 0, 6'd0, 32'h0, 0, 0, 64'h0, 32'h0);

    // R4 64-bit window hit and high-half miss
    mem("R4", 1'b0, 64'h2_1234_5ABC, 32'h0);
    mem("R4", 1'b1, 64'h2_1234_5000, 32'hCAFE_0001);
    mem("R4", 1'b0, 64'h0_1234_5ABC, 32'h0);
    mem("R4", 1'b0, 64'h3_1234_5ABC, 32'h0);

    // R9 misses
    mem("R9", 1'b1, 64'h5551_0000, 32'h2);
    mem("R9", 1'b0, 64'h1_5550_1230, 32'h0);

    // R10 overlap: slot 4 inside slot 0
    cfg_w("R10", 6'd8, 32'h5550_0100);
    mem("R10", 1'b0, 64'h5550_0123, 32'h0);
    cfg_w("R10", 6'd4, 32'h6660_0000);
    mem("R10", 1'b1, 64'h5550_0123, 32'h7777_0000);
    mem("R10", 1'b0, 64'h5550_01FF, 32'h0);
    mem("R10", 1'b0, 64'h5550_0200, 32'h0);

    // config and memory together in one cycle
    cyc("R11", 1, 0, 6'd8, 32'h0, 1, 0, 64'h6660_0004, 32'h0);

    // R6 disable again, request refused
    cfg_w("R6", 6'd1, 32'h0000_0000);
    mem("R6", 1'b0, 64'h6660_0004, 32'h0);
    cfg_r("R6", 6'd1);
    cyc("R11", 0, 0, 6'd0, 32'h0, 0, 0, 64'h0, 32'h0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule